// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Requester Unit

This unit sits between a processor and the memory-side controller that keeps the table of atomic reservations. It holds one local reservation: an address, the key that memory handed out for it, and a valid flag. A load-linked request records the address and starts a lifetime counter. It then sends a one-beat load-linked command. The key that returns with the load data is kept, and the data goes back to the processor.

A store-conditional request is first checked against the local reservation. If there is no live reservation for that address, the unit answers "failure" at once and sends nothing out. If the address matches, the unit drops the local reservation and sends a two-beat command that carries the stored key. It then relays the success or failure that memory reports. A plain write drops the reservation when the address matches, and is always forwarded. A reservation also dies by itself once its lifetime counter has run through 2^LIFE_W cycles after the load-linked request was accepted.

Only one request is in flight at a time. The processor sees `cpu_req_ready` low from acceptance until its response has been delivered.

Top module: `llsc_link_unit`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cmd_valid` and `cpu_rsp_valid` are 0, and no reservation is held, so a store-conditional fails locally.
- R2: A load-linked request (op 2'b01) produces exactly one command beat with `cmd_op`=2'b01, `cmd_addr` equal to the request address, and `cmd_last`=1.
- R3: When the load-linked response arrives (`mem_rsp_valid`), `cpu_rsp_valid` pulses one cycle later with `cpu_rsp_data` equal to `mem_rsp_data`. The key `mem_rsp_key` is stored and the reservation becomes valid.
- R4: A store-conditional (op 2'b10) whose address differs from the reserved one, or that finds no valid reservation, gives `cpu_rsp_valid`=1 with `cpu_rsp_sc_ok`=0 in the cycle after acceptance, and raises no `cmd_valid`.
- R5: A store-conditional that hits sends two beats. Beat 0 has `cmd_op`=2'b10, the address, the stored key in `cmd_key`, and `cmd_last`=0. Beat 1 has `cmd_op`=2'b10, the write data in `cmd_data`, and `cmd_last`=1. The local reservation is cleared, so a repeated store-conditional fails locally.
- R6: For a forwarded store-conditional, `cpu_rsp_sc_ok` equals `mem_rsp_sc_ok` from the memory response, and `cpu_rsp_valid` pulses one cycle after that response.
- R7: A write (op 2'b11) to the reserved address clears the reservation and is forwarded as one beat with `cmd_op`=2'b11, the address, the data and `cmd_last`=1.
- R8: A write to any other address is forwarded the same way and leaves the reservation intact.
- R9: The reservation is lost 2^LIFE_W cycles after its load-linked request was accepted. A store-conditional issued after that fails locally, while one issued well inside the window is forwarded.
- R10: `cpu_req_ready` stays 0 from acceptance until the response pulse. A beat held back by `cmd_ready`=0 keeps all command fields stable.
- R11: A new load-linked request replaces the earlier reservation. A store-conditional to the old address then fails locally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Unit idle and able to accept a request |
| cpu_req_op | input | 2 | 01 load-linked, 10 store-conditional, 11 write, 00 ignored |
| cpu_req_addr | input | AW | Request address |
| cpu_req_data | input | DW | Write data for store-conditional and write |
| cpu_rsp_valid | output | 1 | One-cycle response pulse to the processor |
| cpu_rsp_data | output | DW | Load-linked data |
| cpu_rsp_sc_ok | output | 1 | Store-conditional success flag |
| cmd_valid | output | 1 | Command beat present |
| cmd_ready | input | 1 | Memory side takes the beat |
| cmd_op | output | 2 | Command kind, same encoding as `cpu_req_op` |
| cmd_addr | output | AW | Command address (zero on the store-conditional data beat) |
| cmd_key | output | KW | Reservation key (store-conditional beat 0 only) |
| cmd_data | output | DW | Write data |
| cmd_last | output | 1 | Final beat of the command |
| mem_rsp_valid | input | 1 | Memory response for the outstanding command |
| mem_rsp_data | input | DW | Load-linked data from memory |
| mem_rsp_key | input | KW | Key allocated by memory for a load-linked |
| mem_rsp_sc_ok | input | 1 | Store-conditional outcome from memory |

## Verification
The bench targets the places where the local filter can go wrong. If the address compare ignored the valid flag, a store-conditional right after reset or after an earlier success would be forwarded. If the write path cleared the reservation on any write, the forward after an unrelated write would turn into a local failure. Key replay is checked with a different key for every reservation, so a design that sent a stale key or the wrong beat order would show a mismatched `cmd_key` or `cmd_last`. Lifetime is tested with a short counter on both sides of the expiry point, and a beat stalled by `cmd_ready` is checked for changing fields.

// File: rtl/llsc_pkg.sv
// Shared encodings for the requester-side atomic reservation unit.
// Assumes the processor and the memory side agree on the 2-bit op codes below.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LL   = 2'b01,
        OP_SC   = 2'b10,
        OP_WR   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_LL,
        ST_WAIT_LL,
        ST_SEND_SC0,
        ST_SEND_SC1,
        ST_WAIT_SC,
        ST_SEND_WR,
        ST_WAIT_WR
    } st_e;
endpackage

// File: rtl/llsc_resv_slot.sv
// Single reservation slot: reserved address, key, valid flag and lifetime counter.
// Assumes start, load and drop come from the sequencer. A start overrides everything
// else in the same cycle. A key is taken only while the lifetime window is still open.
module llsc_resv_slot #(
    parameter int AW     = 32,
    parameter int KW     = 32,
    parameter int LIFE_W = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          load_i,
    input  logic [KW-1:0] load_key_i,
    input  logic          drop_i,
    input  logic [AW-1:0] probe_addr_i,
    output logic          hit_o,
    output logic [KW-1:0] key_o
);
    localparam logic [LIFE_W-1:0] CNT_LAST = '1;

    logic [AW-1:0]     addr_q;
    logic [KW-1:0]     key_q;
    logic              valid_q;
    logic              armed_q;
    logic [LIFE_W-1:0] cnt_q;
    logic              expire;

    // Lifetime ends on the cycle the counter sits at its last value.
    assign expire = armed_q && (cnt_q == CNT_LAST);

    // Slot state update: start, count, key capture, invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            key_q   <= '0;
            valid_q <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start_i) begin
            addr_q  <= start_addr_i;
            valid_q <= 1'b0;
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            if (armed_q) cnt_q <= cnt_q + 1'b1;
            if (load_i && armed_q && !expire) begin
                key_q   <= load_key_i;
                valid_q <= 1'b1;
            end
            if (expire || drop_i) begin
                valid_q <= 1'b0;
                armed_q <= 1'b0;
            end
        end
    end

    // Address compare against the live reservation.
    assign hit_o = valid_q && (probe_addr_i == addr_q);
    assign key_o = key_q;

    // R9: a slot whose window closes is no longer valid on the next cycle.
    a_r9_lifetime_end: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start_i) |=> !valid_q);

    // R3: a key accepted inside the window makes the slot valid.
    a_r3_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && armed_q && !expire && !drop_i && !start_i) |=> (valid_q && key_q == $past(load_key_i)));

    // R11: a fresh start always begins without a valid reservation.
    a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_q);
endmodule

// File: rtl/llsc_cmd_fmt.sv
// Command beat formatter: maps sequencer state and latched request to command fields.
// Assumes the sequencer holds the request fields stable for the whole command.
module llsc_cmd_fmt
    import llsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int KW = 32
) (
    input  st_e           state_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    input  logic [KW-1:0] req_key_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_op_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [KW-1:0] cmd_key_o,
    output logic [DW-1:0] cmd_data_o,
    output logic          cmd_last_o
);
    // Beat layout for each send state.
    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_op_o    = OP_NONE;
        cmd_addr_o  = '0;
        cmd_key_o   = '0;
        cmd_data_o  = '0;
        cmd_last_o  = 1'b0;
        unique case (state_i)
            ST_SEND_LL: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_LL;
                cmd_addr_o  = req_addr_i;
                cmd_last_o  = 1'b1;
            end
            ST_SEND_SC0: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_SC;
                cmd_addr_o  = req_addr_i;
                cmd_key_o   = req_key_i;
            end
            ST_SEND_SC1: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_SC;
                cmd_data_o  = req_data_i;
                cmd_last_o  = 1'b1;
            end
            ST_SEND_WR: begin
                cmd_valid_o = 1'b1;
                cmd_op_o    = OP_WR;
                cmd_addr_o  = req_addr_i;
                cmd_data_o  = req_data_i;
                cmd_last_o  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/llsc_seq.sv
// Request sequencer: accepts one processor request at a time, drives the slot,
// walks the command beats and turns the memory response into a processor response.
// Assumes memory answers each command with exactly one response pulse.
module llsc_seq
    import llsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int KW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_data_i,
    output logic          req_ready_o,
    input  logic          hit_i,
    input  logic [KW-1:0] key_i,
    output logic          start_o,
    output logic          load_o,
    output logic          drop_o,
    input  logic          cmd_ready_i,
    output st_e           state_o,
    output logic [AW-1:0] held_addr_o,
    output logic [DW-1:0] held_data_o,
    output logic [KW-1:0] held_key_o,
    input  logic          mrsp_valid_i,
    input  logic [DW-1:0] mrsp_data_i,
    input  logic          mrsp_sc_ok_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o,
    output logic          rsp_sc_ok_o
);
    st_e           state_q, state_d;
    logic          accept;
    logic          is_ll, is_sc, is_wr;
    logic          waiting;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [KW-1:0] key_q;
    logic          rsp_valid_q, rsp_ok_q;
    logic [DW-1:0] rsp_data_q;

    assign accept  = req_valid_i && (state_q == ST_IDLE);
    assign is_ll   = (req_op_i == OP_LL);
    assign is_sc   = (req_op_i == OP_SC);
    assign is_wr   = (req_op_i == OP_WR);
    assign waiting = (state_q == ST_WAIT_LL) || (state_q == ST_WAIT_SC) || (state_q == ST_WAIT_WR);

    // Slot controls derived from the accepted request and the pending response.
    always_comb begin
        start_o = accept && is_ll;
        drop_o  = accept && (is_sc || is_wr) && hit_i;
        load_o  = (state_q == ST_WAIT_LL) && mrsp_valid_i;
    end

    // Next-state selection for the single-outstanding sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (is_ll)               state_d = ST_SEND_LL;
                    else if (is_sc && hit_i) state_d = ST_SEND_SC0;
                    else if (is_wr)          state_d = ST_SEND_WR;
                end
            end
            ST_SEND_LL:  if (cmd_ready_i)  state_d = ST_WAIT_LL;
            ST_SEND_SC0: if (cmd_ready_i)  state_d = ST_SEND_SC1;
            ST_SEND_SC1: if (cmd_ready_i)  state_d = ST_WAIT_SC;
            ST_SEND_WR:  if (cmd_ready_i)  state_d = ST_WAIT_WR;
            ST_WAIT_LL,
            ST_WAIT_SC,
            ST_WAIT_WR:  if (mrsp_valid_i) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the accepted request and the key it will replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            key_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr_i;
            data_q <= req_data_i;
            key_q  <= key_i;
        end
    end

    // Processor response: local failure or relayed memory answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_ok_q    <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept && is_sc && !hit_i) begin
                rsp_valid_q <= 1'b1;
                rsp_ok_q    <= 1'b0;
            end else if (waiting && mrsp_valid_i) begin
                rsp_valid_q <= 1'b1;
                rsp_ok_q    <= (state_q == ST_WAIT_SC) && mrsp_sc_ok_i;
                if (state_q == ST_WAIT_LL) rsp_data_q <= mrsp_data_i;
            end
        end
    end

    assign req_ready_o = (state_q == ST_IDLE);
    assign state_o     = state_q;
    assign held_addr_o = addr_q;
    assign held_data_o = data_q;
    assign held_key_o  = key_q;
    assign rsp_valid_o = rsp_valid_q;
    assign rsp_data_o  = rsp_data_q;
    assign rsp_sc_ok_o = rsp_ok_q;

    // R6: a forwarded SC reports exactly what memory said.
    a_r6_status_relay: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_SC) && mrsp_valid_i) |=> (rsp_valid_o && rsp_sc_ok_o == $past(mrsp_sc_ok_i)));

    // R3: LL data reaches the processor one cycle after the memory response.
    a_r3_data_relay: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_LL) && mrsp_valid_i) |=> (rsp_valid_o && rsp_data_o == $past(mrsp_data_i)));
endmodule

// File: rtl/llsc_link_unit.sv
// Top of the requester-side LL/SC unit: sequencer, reservation slot and beat formatter.
// Assumes one response per command from the memory side and LIFE_W >= 2.
module llsc_link_unit
    import llsc_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int KW     = 32,
    parameter int LIFE_W = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    output logic          cpu_req_ready,
    input  logic [1:0]    cpu_req_op,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_data,
    output logic          cpu_rsp_valid,
    output logic [DW-1:0] cpu_rsp_data,
    output logic          cpu_rsp_sc_ok,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [1:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [KW-1:0] cmd_key,
    output logic [DW-1:0] cmd_data,
    output logic          cmd_last,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    input  logic [KW-1:0] mem_rsp_key,
    input  logic          mem_rsp_sc_ok
);
    logic          hit, start, load, drop;
    logic [KW-1:0] slot_key;
    st_e           state;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;
    logic [KW-1:0] held_key;

    llsc_resv_slot #(.AW(AW), .KW(KW), .LIFE_W(LIFE_W)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_addr_i (cpu_req_addr),
        .load_i       (load),
        .load_key_i   (mem_rsp_key),
        .drop_i       (drop),
        .probe_addr_i (cpu_req_addr),
        .hit_o        (hit),
        .key_o        (slot_key)
    );

    llsc_seq #(.AW(AW), .DW(DW), .KW(KW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (cpu_req_valid),
        .req_op_i     (cpu_req_op),
        .req_addr_i   (cpu_req_addr),
        .req_data_i   (cpu_req_data),
        .req_ready_o  (cpu_req_ready),
        .hit_i        (hit),
        .key_i        (slot_key),
        .start_o      (start),
        .load_o       (load),
        .drop_o       (drop),
        .cmd_ready_i  (cmd_ready),
        .state_o      (state),
        .held_addr_o  (held_addr),
        .held_data_o  (held_data),
        .held_key_o   (held_key),
        .mrsp_valid_i (mem_rsp_valid),
        .mrsp_data_i  (mem_rsp_data),
        .mrsp_sc_ok_i (mem_rsp_sc_ok),
        .rsp_valid_o  (cpu_rsp_valid),
        .rsp_data_o   (cpu_rsp_data),
        .rsp_sc_ok_o  (cpu_rsp_sc_ok)
    );

    llsc_cmd_fmt #(.AW(AW), .DW(DW), .KW(KW)) u_fmt (
        .state_i     (state),
        .req_addr_i  (held_addr),
        .req_data_i  (held_data),
        .req_key_i   (held_key),
        .cmd_valid_o (cmd_valid),
        .cmd_op_o    (cmd_op),
        .cmd_addr_o  (cmd_addr),
        .cmd_key_o   (cmd_key),
        .cmd_data_o  (cmd_data),
        .cmd_last_o  (cmd_last)
    );

    // R4: an SC with no matching reservation fails next cycle without a command.
    a_r4_local_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && cpu_req_op == OP_SC && !hit)
        |=> (cpu_rsp_valid && !cpu_rsp_sc_ok && !cmd_valid));

    // R2: LL and write commands are single beats.
    a_r2_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_LL || cmd_op == OP_WR)) |-> cmd_last);

    // R5: an accepted SC head beat is followed by its closing beat.
    a_r5_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_SC && !cmd_last)
        |=> (cmd_valid && cmd_op == OP_SC && cmd_last));

    // R10: a stalled beat keeps its fields.
    a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
            && $stable(cmd_key) && $stable(cmd_data) && $stable(cmd_last)));

    // R10: no new request while a command is on the wire.
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cpu_req_ready);
endmodule

// File: tb/sim_llsc_link_unit.sv
`timescale 1ns/1ps
module sim_llsc_link_unit;
    localparam int AW = 32, DW = 32, KW = 32, LIFE_W = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic [1:0]    cpu_req_op = 2'b00;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_data = '0;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_data;
    logic          cpu_rsp_sc_ok;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [KW-1:0] cmd_key;
    logic [DW-1:0] cmd_data;
    logic          cmd_last;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic [KW-1:0] mem_rsp_key = '0;
    logic          mem_rsp_sc_ok = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    llsc_link_unit #(.AW(AW), .DW(DW), .KW(KW), .LIFE_W(LIFE_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_req_ready == 1'b1, "R1 ready", cpu_req_ready, 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(cpu_rsp_valid == 1'b0, "R1 rsp_valid", cpu_rsp_valid, 0);
    endtask

    task automatic t_ll(input logic [AW-1:0] a, input logic [KW-1:0] k, input logic [DW-1:0] d);
        cpu_req_valid = 1'b1; cpu_req_op = 2'b01; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cpu_req_ready == 1'b0, "R10 busy after LL", cpu_req_ready, 0);
        chk(cmd_valid && cmd_op == 2'b01 && cmd_last, "R2 LL beat", {cmd_valid, cmd_op, cmd_last}, {1'b1, 2'b01, 1'b1});
        chk(cmd_addr == a, "R2 LL addr", cmd_addr, a);
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R2 single beat", cmd_valid, 0);
        mem_rsp_valid = 1'b1; mem_rsp_data = d; mem_rsp_key = k;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(cpu_rsp_valid && cpu_rsp_data == d, "R3 LL data", cpu_rsp_data, d);
        chk(cpu_req_ready == 1'b1, "R10 ready after LL", cpu_req_ready, 1);
    endtask

    task automatic t_sc_local(input logic [AW-1:0] a, input string req);
        cpu_req_valid = 1'b1; cpu_req_op = 2'b10; cpu_req_addr = a; cpu_req_data = 32'hDEAD0000;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cpu_rsp_valid && !cpu_rsp_sc_ok, req, {cpu_rsp_valid, cpu_rsp_sc_ok}, 2'b10);
        chk(cmd_valid == 1'b0, req, cmd_valid, 0);
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R4 no command", cmd_valid, 0);
    endtask

    task automatic t_sc_fwd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [KW-1:0] k,
                            input bit ok, input int stall, input string req);
        cpu_req_valid = 1'b1; cpu_req_op = 2'b10; cpu_req_addr = a; cpu_req_data = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (stall > 0) cmd_ready = 1'b0;
        chk(cmd_valid && cmd_op == 2'b10 && !cmd_last, {req, " R5 beat0"}, {cmd_valid, cmd_op, cmd_last}, {1'b1, 2'b10, 1'b0});
        chk(cmd_addr == a && cmd_key == k, {req, " R5 key"}, {cmd_addr, cmd_key}, {a, k});
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(cmd_valid && !cmd_last && cmd_key == k && cmd_addr == a, "R10 stalled beat held", cmd_key, k);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        chk(cmd_valid && cmd_op == 2'b10 && cmd_last, "R5 beat1", {cmd_valid, cmd_op, cmd_last}, {1'b1, 2'b10, 1'b1});
        chk(cmd_data == d, "R5 data", cmd_data, d);
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R5 two beats only", cmd_valid, 0);
        mem_rsp_valid = 1'b1; mem_rsp_sc_ok = ok;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_sc_ok = 1'b0;
        chk(cpu_rsp_valid && cpu_rsp_sc_ok == ok, "R6 status", {cpu_rsp_valid, cpu_rsp_sc_ok}, {1'b1, ok});
    endtask

    task automatic t_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        cpu_req_valid = 1'b1; cpu_req_op = 2'b11; cpu_req_addr = a; cpu_req_data = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cmd_valid && cmd_op == 2'b11 && cmd_last, req, {cmd_valid, cmd_op, cmd_last}, {1'b1, 2'b11, 1'b1});
        chk(cmd_addr == a && cmd_data == d, req, {cmd_addr, cmd_data}, {a, d});
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(cpu_rsp_valid == 1'b1, {req, " ack"}, cpu_rsp_valid, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_sc_local(32'h100, "R1 SC after reset fails");

        t_ll(32'h100, 32'hA0000001, 32'h11111111);
        t_sc_fwd(32'h100, 32'h5A5A0001, 32'hA0000001, 1'b1, 0, "R6 ok");
        t_sc_local(32'h100, "R5 reservation cleared");

        t_ll(32'h200, 32'hA0000002, 32'h22222222);
        t_sc_local(32'h204, "R4 address mismatch");
        t_sc_fwd(32'h200, 32'h5A5A0002, 32'hA0000002, 1'b0, 2, "R6 fail");

        t_ll(32'h300, 32'hA0000003, 32'h33333333);
        t_wr(32'h340, 32'h77770003, "R8 other write");
        t_sc_fwd(32'h300, 32'h5A5A0003, 32'hA0000003, 1'b1, 0, "R8 kept");

        t_ll(32'h400, 32'hA0000004, 32'h44444444);
        t_wr(32'h400, 32'h77770004, "R7 same write");
        t_sc_local(32'h400, "R7 write cleared");

        t_ll(32'h500, 32'hA0000005, 32'h55555555);
        t_ll(32'h600, 32'hA0000006, 32'h66666666);
        t_sc_local(32'h500, "R11 old address");
        t_sc_fwd(32'h600, 32'h5A5A0006, 32'hA0000006, 1'b1, 0, "R11 new");

        t_ll(32'h700, 32'hA0000007, 32'h77777777);
        repeat (20) @(negedge clk);
        t_sc_local(32'h700, "R9 expired");

        t_ll(32'h800, 32'hA0000008, 32'h88888888);
        repeat (8) @(negedge clk);
        t_sc_fwd(32'h800, 32'h5A5A0008, 32'hA0000008, 1'b1, 0, "R9 in window");

        summary();
        $finish;
    end
endmodule